// File: doc/BRIEF.md
# Interrupt Router Register Window

This block gives software an indirect, memory-mapped view of the configuration registers of an interrupt router. A small select register chooses one internal register by index, and a 32-bit data window reads or writes the chosen register. The internal registers are an identification register, a read-only version word, an arbitration word that mirrors the identification field, and a table of redirection entries. Each entry is 64 bits wide and appears as two 32-bit halves at neighbouring indices.

The block holds the redirection table and presents every entry to the delivery logic on a flat output bus. Whenever software writes either half of an entry, the block raises a one-cycle rescan request so that the delivery logic can re-evaluate pending interrupts. One bit of each entry, the remote-pending flag, is owned by the delivery logic. It enters on its own input, is shown in reads and can never be changed through the window. Reads return data one cycle after the request.

Top module: `irw_window`

## Requirements
- R1: After reset the select register is 0x00, the identification field is 0, every redirection entry holds only its mask bit (bit 16 of the low half) set, and no rescan request is raised.
- R2: Only the low 8 address bits are decoded. A write to offset 0x00 stores wdata[7:0] in the select register at any access size, and a read of offset 0x00 returns the select value zero-extended, at any access size.
- R3: Offset 0x10 is the data window. A window access whose size is not 4 bytes changes no register and no entry, and such a read returns zero.
- R4: A window read with select 0x00 (identification) or 0x02 (arbitration) returns the identification field in bits 27:24 and zero elsewhere. A window write with select 0x00 stores only wdata[27:24].
- R5: A window read with select 0x01 returns 0x11 ORed with (entry count - 1) shifted left by 16. Window writes with select 0x01 or 0x02 change nothing.
- R6: A select value of 0x10 + 2n + h addresses entry n, the low half when h = 0 and the high half when h = 1. A window write replaces only that half, and the new value is visible on entries_o and in later reads from the next cycle on.
- R7: rescan_req pulses high for exactly one cycle, the cycle after a 4-byte window write to a valid entry half, and stays low after every other kind of access.
- R8: Select values that are neither 0x00-0x02 nor a valid entry half (0x03-0x0F, and 0x10 + 2 x entry count and above) read as zero through the window and ignore window writes.
- R9: Bit 14 of an entry's low half (remote-pending) always reads as the entry's remote_irr input. Writes never store it, and entries_o carries it as zero.
- R10: rsp_valid is high in exactly the cycle after each read request. A read of any offset other than 0x00 or 0x10 returns zero, and writes to such offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; only the low 8 bits are decoded |
| req_size | input | 3 | Access size in bytes (4 = full word) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_data | output | 32 | Read data |
| remote_irr | input | NUM_PINS | Remote-pending flag of each entry, owned by the delivery logic |
| entries_o | output | 64*NUM_PINS | All redirection entries, entry n at bits 64n+63:64n |
| rescan_req | output | 1 | One-cycle pulse after any entry write |

## Verification
The bench builds the block with NUM_PINS = 6 and ADDR_W = 12. With six entries the top of the table (select 0x1B) and the first index past it (0x1C) are a few accesses away, and the version word changes to 0x00050011, which shows that the entry-count field follows the parameter. The wider address lets the bench set bits above bit 7 and confirm that the decode ignores them. Expected read words go into a queue as each request is issued. A monitor takes them out as responses arrive, and the bench checks entries_o and rescan_req directly after each write.

// File: rtl/irw_pkg.sv
package irw_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned ENTRY_W = 64;

    // What the current select value points at.
    typedef enum logic [2:0] {
        SEL_IDENT = 3'd0,
        SEL_VER   = 3'd1,
        SEL_ARB   = 3'd2,
        SEL_ENTRY = 3'd3,
        SEL_NONE  = 3'd4
    } sel_kind_e;

endpackage

// File: rtl/irw_decode.sv
module irw_decode
    import irw_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 24,
    parameter int unsigned SEL_W     = 8,
    parameter int unsigned IDX_IDENT = 0,
    parameter int unsigned IDX_VER   = 1,
    parameter int unsigned IDX_ARB   = 2,
    parameter int unsigned TBL_BASE  = 16,
    localparam int unsigned IDX_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic [SEL_W-1:0] sel_i,
    output sel_kind_e        kind_o,
    output logic [IDX_W-1:0] ent_idx_o,
    output logic             upper_o
);

    logic [SEL_W-1:0] rel;
    logic             in_table;

    always_comb begin
        rel      = sel_i - SEL_W'(TBL_BASE);
        in_table = (sel_i >= SEL_W'(TBL_BASE)) &&
                   ({1'b0, rel[SEL_W-1:1]} < SEL_W'(NUM_PINS));
        ent_idx_o = IDX_W'(rel[SEL_W-1:1]);
        upper_o   = rel[0];
        if (sel_i == SEL_W'(IDX_IDENT))      kind_o = SEL_IDENT;
        else if (sel_i == SEL_W'(IDX_VER))   kind_o = SEL_VER;
        else if (sel_i == SEL_W'(IDX_ARB))   kind_o = SEL_ARB;
        else if (in_table)                   kind_o = SEL_ENTRY;
        else                                 kind_o = SEL_NONE;
    end

endmodule

// File: rtl/irw_table.sv
module irw_table
    import irw_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 24,
    parameter int unsigned MASK_BIT   = 16,
    parameter int unsigned REMOTE_BIT = 14,
    localparam int unsigned IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we_i,
    input  logic [IDX_W-1:0]            widx_i,
    input  logic                        whi_i,
    input  logic [WORD_W-1:0]           wdata_i,
    input  logic [IDX_W-1:0]            ridx_i,
    input  logic [NUM_PINS-1:0]         remote_i,
    output logic [WORD_W-1:0]           rd_lo_o,
    output logic [WORD_W-1:0]           rd_hi_o,
    output logic [NUM_PINS*ENTRY_W-1:0] entries_o
);

    localparam logic [ENTRY_W-1:0] ENTRY_RST = ENTRY_W'(1) << MASK_BIT;

    logic [ENTRY_W-1:0] ent_q [NUM_PINS];
    logic [ENTRY_W-1:0] ent_d [NUM_PINS];

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (we_i && (widx_i == IDX_W'(i))) begin
                if (whi_i) ent_d[i][ENTRY_W-1:WORD_W] = wdata_i;
                else       ent_d[i][WORD_W-1:0]       = wdata_i;
            end
            ent_d[i][REMOTE_BIT] = 1'b0;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q[i] <= ENTRY_RST;
            else        ent_q[i] <= ent_d[i];
        end

        assign entries_o[i*ENTRY_W +: ENTRY_W] = ent_q[i];

        // R6: an entry not addressed by a write keeps its value
        p_entry_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (widx_i == IDX_W'(i))) |=> $stable(entries_o[i*ENTRY_W +: ENTRY_W]));
    end

    always_comb begin
        rd_lo_o = '0;
        rd_hi_o = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (ridx_i == IDX_W'(i)) begin
                rd_lo_o             = ent_q[i][WORD_W-1:0];
                rd_hi_o             = ent_q[i][ENTRY_W-1:WORD_W];
                rd_lo_o[REMOTE_BIT] = remote_i[i];
            end
        end
    end

endmodule

// File: rtl/irw_window.sv
module irw_window
    import irw_pkg::*;
#(
    parameter int unsigned NUM_PINS   = 24,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DEC_W      = 8,
    parameter int unsigned SEL_W      = 8,
    parameter int unsigned OFF_SEL    = 8'h00,
    parameter int unsigned OFF_WIN    = 8'h10,
    parameter int unsigned TBL_BASE   = 8'h10,
    parameter int unsigned VER_CODE   = 8'h11,
    parameter int unsigned CNT_LSB    = 16,
    parameter int unsigned ID_W       = 4,
    parameter int unsigned ID_LSB     = 24,
    parameter int unsigned MASK_BIT   = 16,
    parameter int unsigned REMOTE_BIT = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [ADDR_W-1:0]           req_addr,
    input  logic [2:0]                  req_size,
    input  logic [WORD_W-1:0]           req_wdata,
    output logic                        rsp_valid,
    output logic [WORD_W-1:0]           rsp_data,
    input  logic [NUM_PINS-1:0]         remote_irr,
    output logic [NUM_PINS*ENTRY_W-1:0] entries_o,
    output logic                        rescan_req
);

    localparam int unsigned IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam logic [WORD_W-1:0] VER_WORD =
        WORD_W'(VER_CODE) | (WORD_W'(NUM_PINS - 1) << CNT_LSB);

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ID_W-1:0]   id;
        logic              rsp_valid;
        logic [WORD_W-1:0] rsp_data;
        logic              rescan;
    } win_state_t;

    win_state_t st_d, st_q;

    sel_kind_e         kind;
    logic [IDX_W-1:0]  ent_idx;
    logic              upper;
    logic [WORD_W-1:0] rd_lo, rd_hi;
    logic              tbl_we;
    logic [DEC_W-1:0]  dec_addr;
    logic              hit_sel, hit_win, full_word;
    logic              unused_addr_hi;

    assign dec_addr       = req_addr[DEC_W-1:0];
    assign unused_addr_hi = ^req_addr[ADDR_W-1:DEC_W];
    assign hit_sel        = req_valid && (dec_addr == DEC_W'(OFF_SEL));
    assign hit_win        = req_valid && (dec_addr == DEC_W'(OFF_WIN));
    assign full_word      = (req_size == 3'd4);

    irw_decode #(
        .NUM_PINS (NUM_PINS),
        .SEL_W    (SEL_W),
        .IDX_IDENT(0),
        .IDX_VER  (1),
        .IDX_ARB  (2),
        .TBL_BASE (TBL_BASE)
    ) u_decode (
        .sel_i    (st_q.sel),
        .kind_o   (kind),
        .ent_idx_o(ent_idx),
        .upper_o  (upper)
    );

    irw_table #(
        .NUM_PINS  (NUM_PINS),
        .MASK_BIT  (MASK_BIT),
        .REMOTE_BIT(REMOTE_BIT)
    ) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (tbl_we),
        .widx_i   (ent_idx),
        .whi_i    (upper),
        .wdata_i  (req_wdata),
        .ridx_i   (ent_idx),
        .remote_i (remote_irr),
        .rd_lo_o  (rd_lo),
        .rd_hi_o  (rd_hi),
        .entries_o(entries_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rescan    = 1'b0;
        st_d.rsp_valid = req_valid && !req_write;
        st_d.rsp_data  = '0;
        tbl_we         = 1'b0;

        if (req_write) begin
            if (hit_sel) begin
                st_d.sel = req_wdata[SEL_W-1:0];
            end else if (hit_win && full_word) begin
                case (kind)
                    SEL_IDENT: st_d.id = req_wdata[ID_LSB +: ID_W];
                    SEL_ENTRY: begin
                        tbl_we      = 1'b1;
                        st_d.rescan = 1'b1;
                    end
                    default: ;
                endcase
            end
        end else begin
            if (hit_sel) begin
                st_d.rsp_data = WORD_W'(st_q.sel);
            end else if (hit_win && full_word) begin
                case (kind)
                    SEL_IDENT, SEL_ARB: st_d.rsp_data = WORD_W'(st_q.id) << ID_LSB;
                    SEL_VER:            st_d.rsp_data = VER_WORD;
                    SEL_ENTRY:          st_d.rsp_data = upper ? rd_hi : rd_lo;
                    default:            st_d.rsp_data = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_data   = st_q.rsp_data;
    assign rescan_req = st_q.rescan;

    // R7: a rescan is always preceded by a full-word window write to an entry
    p_rescan_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rescan_req |-> $past(hit_win && req_write && full_word && (kind == SEL_ENTRY)));

    // R3: narrow window writes leave the table and the identification alone
    p_narrow_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win && req_write && !full_word) |=> ($stable(entries_o) && $stable(st_q.id)));

    // R3: narrow window reads return zero
    p_narrow_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win && !req_write && !full_word) |=> (rsp_valid && (rsp_data == '0)));

    // R2: the select register changes only on a write to its offset
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_sel && req_write) |=> $stable(st_q.sel));

    // R5: version reads return the fixed word
    p_version_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_win && !req_write && full_word && (kind == SEL_VER)) |=> (rsp_data == VER_WORD));

    // R10: response valid follows each read request by one cycle
    p_rsp_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rsp_valid);

endmodule

// File: tb/irw_window_test.sv
module irw_window_test;

    localparam int unsigned NP     = 6;
    localparam int unsigned AW     = 12;
    localparam logic [31:0] MASKV  = 32'h0001_0000;
    localparam logic [31:0] VERW   = 32'h11 | ((NP - 1) << 16);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic               req_write = 1'b0;
    logic [AW-1:0]      req_addr = '0;
    logic [2:0]         req_size = 3'd4;
    logic [31:0]        req_wdata = '0;
    logic               rsp_valid;
    logic [31:0]        rsp_data;
    logic [NP-1:0]      remote_irr = '0;
    logic [NP*64-1:0]   entries_o;
    logic               rescan_req;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    always #5ns clk = ~clk;

    irw_window #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .remote_irr(remote_irr),
        .entries_o(entries_o), .rescan_req(rescan_req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares each read response with the oldest expected word.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check("R10 unexpected response", 64'(rsp_data), 64'hx);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, 64'(rsp_data), 64'(e.data));
            end
        end
    end

    task automatic access(input logic wr, input logic [AW-1:0] a,
                          input logic [2:0] sz, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        @(posedge clk);
        #1ns;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [2:0] sz,
                      input logic [31:0] exp, input string tag);
        exp_t e;
        e.data = exp;
        e.tag  = tag;
        exp_q.push_back(e);
        access(1'b0, a, sz, '0);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [2:0] sz, input logic [31:0] wd,
                      input logic exp_rescan, input string tag);
        access(1'b1, a, sz, wd);
        check(tag, 64'(rescan_req), 64'(exp_rescan));
    endtask

    task automatic win_rd(input logic [7:0] sel, input logic [31:0] exp, input string tag);
        wr(12'h000, 3'd4, 32'(sel), 1'b0, "R7 no rescan on select write");
        rd(12'h010, 3'd4, exp, tag);
    endtask

    initial begin
        #2ms;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1ns;
        rst_n = 1'b1;
        #1ns;
        // R1: reset state
        for (int i = 0; i < NP; i++)
            check("R1 entry reset", entries_o[i*64 +: 64], 64'(MASKV));
        check("R1 rescan low", 64'(rescan_req), 64'd0);
        rd(12'h000, 3'd4, 32'h0, "R1 select reset");
        rd(12'h010, 3'd4, 32'h0, "R1 ident reset");

        // R2: select at any size, upper address bits ignored
        wr(12'h000, 3'd1, 32'hFFFF_FFAB, 1'b0, "R7 no rescan");
        rd(12'h000, 3'd2, 32'h0000_00AB, "R2 select readback");
        wr(12'h500, 3'd4, 32'h0000_0001, 1'b0, "R7 no rescan");
        rd(12'hA00, 3'd1, 32'h0000_0001, "R2 high address bits ignored");

        // R5: version word, writes ignored
        rd(12'h310, 3'd4, VERW, "R5 version read");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 no rescan on version write");
        rd(12'h010, 3'd4, VERW, "R5 version after write");

        // R4: ident and arbitration
        win_rd(8'h02, 32'h0, "R4 arbitration initial");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, "R5 arbitration write no rescan");
        rd(12'h010, 3'd4, 32'h0, "R5 arbitration write ignored");
        wr(12'h000, 3'd4, 32'h0, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF, 1'b0, "R7 no rescan on ident write");
        rd(12'h010, 3'd4, 32'h0F00_0000, "R4 ident masked");
        win_rd(8'h02, 32'h0F00_0000, "R4 arbitration mirrors ident");

        // R3: narrow window accesses
        wr(12'h000, 3'd4, 32'h0, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd2, 32'h0, 1'b0, "R3 narrow write no rescan");
        rd(12'h010, 3'd4, 32'h0F00_0000, "R3 narrow write ignored");
        rd(12'h010, 3'd1, 32'h0, "R3 narrow read zero");
        wr(12'h000, 3'd4, 32'h10, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd2, 32'h1234_0000, 1'b0, "R3 narrow entry write no rescan");
        check("R3 entry untouched", entries_o[63:0], 64'(MASKV));

        // R6, R7, R9: entry 0 halves
        wr(12'h010, 3'd4, 32'h1234_5678, 1'b1, "R7 rescan on low write");
        check("R6 low half stored", entries_o[63:0], 64'h0000_0000_1234_1678);
        rd(12'h010, 3'd4, 32'h1234_1678, "R9 remote bit not stored");
        wr(12'h000, 3'd4, 32'h11, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd4, 32'hDEAD_BEEF, 1'b1, "R7 rescan on high write");
        check("R6 high half stored", entries_o[63:0], 64'hDEAD_BEEF_1234_1678);
        rd(12'h010, 3'd4, 32'hDEAD_BEEF, "R6 high readback");
        win_rd(8'h10, 32'h1234_1678, "R6 low unchanged by high write");
        remote_irr = 6'b000001;
        rd(12'h010, 3'd4, 32'h1234_5678, "R9 remote bit reflects input");
        wr(12'h010, 3'd4, 32'h0, 1'b1, "R7 rescan");
        rd(12'h010, 3'd4, 32'h0000_4000, "R9 write cannot clear remote");
        check("R9 entries carry remote zero", entries_o[63:0], 64'hDEAD_BEEF_0000_0000);
        remote_irr = '0;

        // R6: last entry, high half
        wr(12'h000, 3'd4, 32'h1B, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd4, 32'hCAFE_F00D, 1'b1, "R7 rescan on last entry");
        check("R6 last entry", entries_o[5*64 +: 64], 64'hCAFE_F00D_0001_0000);
        check("R6 neighbour untouched", entries_o[4*64 +: 64], 64'(MASKV));
        rd(12'h010, 3'd4, 32'hCAFE_F00D, "R6 last entry readback");

        // R8: out-of-range selects
        wr(12'h000, 3'd4, 32'h1C, 1'b0, "R7 no rescan");
        wr(12'h010, 3'd4, 32'h5555_5555, 1'b0, "R8 no rescan past table");
        rd(12'h010, 3'd4, 32'h0, "R8 past table reads zero");
        win_rd(8'h05, 32'h0, "R8 gap index reads zero");
        win_rd(8'h0F, 32'h0, "R8 index 0x0F reads zero");
        for (int i = 0; i < NP; i++)
            if (i != 0 && i != 5)
                check("R8 entries untouched", entries_o[i*64 +: 64], 64'(MASKV));

        // R10: other offsets
        wr(12'h008, 3'd4, 32'hFFFF_FFFF, 1'b0, "R10 other offset no rescan");
        rd(12'h008, 3'd4, 32'h0, "R10 other offset reads zero");
        rd(12'h000, 3'd4, 32'h0F, "R10 select unchanged by other offset");

        repeat (3) @(posedge clk);
        #1ns;
        check("R10 all responses seen", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule